// File: doc/BRIEF.md
# Multichannel Audio Sample FIFO

This block buffers audio samples travelling in one direction between a processor bus and a serial audio port. A parameter picks the direction. In a transmit instance the processor writes samples and the port drains them. In a receive instance the port fills the buffer and the processor reads it. The processor sees three word registers: control, status and data. Data words carry one sample in their low 24 bits, so a 16-bit sample sits left-justified in bits 23:8.

Occupancy is counted in frames, not words. A frame is one sample for each configured channel. The usable depth follows from a RAM size code and from the channel count. The channel count is first rounded up to a power of two, so three channels use the same frame capacity as four. The status register reports the number of complete frames. It also holds sticky flags for writes dropped because the buffer was full and for reads taken from an empty buffer. An optional interrupt marks the half-full crossing, in the direction that suits the data flow.

Top module: `audio_sample_fifo`

## Requirements
- R1: Total depth in words is 256 shifted left by the size code (control bits 10:8). A code above parameter MAX_SIZE_CODE is clamped to it, and the control register reads back the clamped code. Frame capacity is the total depth shifted right by ceil(log2(channels)). Channels is control bits 6:4 plus one.
- R2: Status bits 16:8 report the number of complete buffered frames. The field saturates at 511.
- R3: A frame counts toward the level only once all of its channel samples have been written. Reads take samples from complete frames only.
- R4: A write that arrives while the held word count equals frame capacity times channels is dropped, and it sets status bit 4, the overrun flag.
- R5: A read that arrives while no complete frame is held returns zero, and it sets status bit 0, the underrun flag.
- R6: A status write clears bit 4 and bit 0 individually wherever it writes a zero. A one leaves the flag unchanged, and a new event in the same cycle wins over the clear.
- R7: A control write with bit 0 set empties the buffer (level, partial frames and pointers) while leaving the flags alone. Bit 0 always reads back as zero.
- R8: Control bit 20 enables the irq output. A transmit instance raises irq while the level is at or below half the frame capacity. A receive instance raises it while the level is at or above that half. irq stays low while bit 20 is clear.
- R9: Only bits 23:0 of a data word are stored. Every data read returns zero in bits 31:24.
- R10: Samples leave in the order they were accepted.
- R11: New channel or size fields in a control write are taken only if the buffer holds no words or the same write sets bit 0. Otherwise the old configuration stays. A configuration change that is taken also empties the buffer.
- R12: Register addresses are 0 for control, 1 for status and 2 for data. Read data appears on bus_rdata, and popped port data on port_rdata, in the cycle after the strobe. Transmit instances use the bus to write data and port_pop to read it. Receive instances use port_push to write data and the bus to read it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| port_push | input | 1 | Port-side sample write (receive instance) |
| port_wdata | input | 24 | Port-side sample |
| port_pop | input | 1 | Port-side sample read (transmit instance) |
| port_rdata | output | 24 | Popped sample, valid the cycle after port_pop |
| irq | output | 1 | Half-level interrupt request |

## Verification
The bench goes after the capacity edge for 1, 3, 5 and 8 channels. A design that ignored the power-of-two rounding would accept too many words before flagging overrun. It also writes partial frames. A design that counted words rather than frames would show a non-zero level early, or would let the port drain a half-written frame. It tests the saturation of the level field at 512 frames, where a truncating design would report zero. It tests the lock on configuration changes while data is held, where a lax design would reinterpret the buffered words. It also checks per-bit flag clearing, the zero returned by an underrun read, and the direction-dependent half threshold on both instance types.

// File: rtl/asf_pkg.sv
package asf_pkg;

    localparam int DATA_W       = 24;
    localparam int BUS_W        = 32;
    localparam int LVL_W        = 9;

    localparam int CTRL_CLR_BIT = 0;
    localparam int CTRL_CH_LSB  = 4;
    localparam int CTRL_SZ_LSB  = 8;
    localparam int CTRL_IRQ_BIT = 20;

    localparam int STAT_UDR_BIT = 0;
    localparam int STAT_OVR_BIT = 4;
    localparam int STAT_LVL_LSB = 8;

    typedef enum logic [1:0] {
        ASF_REG_CTRL = 2'd0,
        ASF_REG_STAT = 2'd1,
        ASF_REG_DATA = 2'd2,
        ASF_REG_NONE = 2'd3
    } asf_reg_e;

    typedef struct packed {
        logic [2:0] size_code;
        logic [2:0] chan_m1;
    } asf_cfg_t;

    typedef struct packed {
        logic ovr;
        logic udr;
    } asf_flags_t;

    // ceil(log2(channels)) for channels = chan_m1 + 1 in 1..8
    function automatic logic [1:0] chan_shift(input logic [2:0] chan_m1);
        if (chan_m1 == 3'd0)      return 2'd0;
        else if (chan_m1 == 3'd1) return 2'd1;
        else if (chan_m1 <= 3'd3) return 2'd2;
        else                      return 2'd3;
    endfunction

    function automatic logic [2:0] clamp_size(input logic [2:0] code, input int unsigned max_code);
        if (32'(code) > max_code) return 3'(max_code);
        return code;
    endfunction

endpackage

// File: rtl/asf_geometry.sv
module asf_geometry
    import asf_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  asf_cfg_t         cfg,
    output logic [CNT_W-1:0] cap_words,
    output logic [CNT_W-1:0] half_frames
);

    localparam logic [CNT_W-1:0] BASE_WORDS = CNT_W'(256);

    logic [CNT_W-1:0] total_words;
    logic [CNT_W-1:0] cap_frames;
    logic [CNT_W-1:0] chans;

    always_comb begin
        total_words = BASE_WORDS << cfg.size_code;
        cap_frames  = total_words >> chan_shift(cfg.chan_m1);
        chans       = CNT_W'(cfg.chan_m1) + CNT_W'(1);
        cap_words   = cap_frames * chans;
        half_frames = cap_frames >> 1;
    end

endmodule

// File: rtl/asf_ram.sv
module asf_ram #(
    parameter int AW = 10,
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic          rd_zero,
    output logic [DW-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst)          rd_data <= '0;
        else if (rd_en)   rd_data <= mem[rd_addr];
        else if (rd_zero) rd_data <= '0;
    end

endmodule

// File: rtl/asf_tracker.sv
module asf_tracker
    import asf_pkg::*;
#(
    parameter int AW    = 10,
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push_req,
    input  logic             pop_req,
    input  logic [2:0]       chan_m1,
    input  logic [CNT_W-1:0] cap_words,
    input  logic             stat_wr,
    input  asf_flags_t       stat_keep,
    output logic             push_ok,
    output logic             pop_ok,
    output logic             pop_empty,
    output logic [AW-1:0]    wr_ptr,
    output logic [AW-1:0]    rd_ptr,
    output logic [CNT_W-1:0] words,
    output logic [CNT_W-1:0] frames,
    output asf_flags_t       flags
);

    localparam int ACC_W = CNT_W + 4;

    logic [2:0] wr_slot, rd_slot;
    logic       room, has_frame, push_drop, wr_wrap, rd_wrap;

    always_comb begin
        room      = words < cap_words;
        has_frame = frames != '0;
        push_ok   = push_req & ~clr & room;
        push_drop = push_req & ~clr & ~room;
        pop_ok    = pop_req & ~clr & has_frame;
        pop_empty = pop_req & ~clr & ~has_frame;
        wr_wrap   = wr_slot == chan_m1;
        rd_wrap   = rd_slot == chan_m1;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            words   <= '0;
            frames  <= '0;
            wr_slot <= '0;
            rd_slot <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr  <= wr_ptr + 1'b1;
                wr_slot <= wr_wrap ? 3'd0 : wr_slot + 3'd1;
            end
            if (pop_ok) begin
                rd_ptr  <= rd_ptr + 1'b1;
                rd_slot <= rd_wrap ? 3'd0 : rd_slot + 3'd1;
            end
            words  <= words + CNT_W'(push_ok) - CNT_W'(pop_ok);
            frames <= frames + CNT_W'(push_ok & wr_wrap) - CNT_W'(pop_ok & rd_wrap);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            if (push_drop)                      flags.ovr <= 1'b1;
            else if (stat_wr && !stat_keep.ovr) flags.ovr <= 1'b0;
            if (pop_empty)                      flags.udr <= 1'b1;
            else if (stat_wr && !stat_keep.udr) flags.udr <= 1'b0;
        end
    end

    // word count rebuilt from frame count and the two partial-frame slots
    logic [ACC_W-1:0] acct;
    always_comb begin
        acct = ACC_W'(frames) * ACC_W'(chan_m1) + ACC_W'(frames)
             + ACC_W'(wr_slot) - ACC_W'(rd_slot);
    end

    AST_WORDS_BOUND: assert property (@(posedge clk) disable iff (rst)
        words <= cap_words);                                            // R4
    AST_COUNT_AGREE: assert property (@(posedge clk) disable iff (rst)
        acct == ACC_W'(words));                                         // R3
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr |=> (words == '0 && frames == '0));                         // R7
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flags.ovr && !(stat_wr && !stat_keep.ovr)) |=> flags.ovr);     // R6
    AST_UDR_RAISE: assert property (@(posedge clk) disable iff (rst)
        (pop_req && !clr && frames == '0) |=> flags.udr);               // R5

endmodule

// File: rtl/audio_sample_fifo.sv
module audio_sample_fifo
    import asf_pkg::*;
#(
    parameter bit IS_TX         = 1'b1,
    parameter int MAX_SIZE_CODE = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        port_push,
    input  logic [23:0] port_wdata,
    input  logic        port_pop,
    output logic [23:0] port_rdata,
    output logic        irq
);

    localparam int AW    = 8 + MAX_SIZE_CODE;
    localparam int CNT_W = AW + 1;

    asf_reg_e         reg_sel;
    logic             acc_wr, acc_rd, ctrl_wr, stat_wr, data_wr, data_rd;
    asf_cfg_t         cfg_q, req_cfg;
    logic             irq_en_q, cfg_take, clr;
    logic             push_req, pop_req;
    logic [DATA_W-1:0] push_data, ram_q;
    logic             push_ok, pop_ok, pop_empty;
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CNT_W-1:0] words, frames, cap_words, half_frames;
    asf_flags_t       flags, stat_keep;
    logic [LVL_W-1:0] lvl_view;
    logic [BUS_W-1:0] ctrl_view, stat_view, rd_reg_q;
    logic             rd_from_ram_q;
    logic             unused_sink;

    assign unused_sink = ^{bus_wdata[31:24], port_wdata, port_push, port_pop};

    // ---------------- register decode ----------------
    always_comb begin
        reg_sel = asf_reg_e'(bus_addr);
        acc_wr  = bus_sel & bus_wr;
        acc_rd  = bus_sel & ~bus_wr;
        ctrl_wr = acc_wr & (reg_sel == ASF_REG_CTRL);
        stat_wr = acc_wr & (reg_sel == ASF_REG_STAT);
        data_wr = acc_wr & (reg_sel == ASF_REG_DATA);
        data_rd = acc_rd & (reg_sel == ASF_REG_DATA);
        req_cfg.chan_m1   = bus_wdata[CTRL_CH_LSB +: 3];
        req_cfg.size_code = clamp_size(bus_wdata[CTRL_SZ_LSB +: 3], MAX_SIZE_CODE);
        cfg_take  = ctrl_wr & (bus_wdata[CTRL_CLR_BIT] | (words == '0));
        clr       = ctrl_wr & (bus_wdata[CTRL_CLR_BIT] | (cfg_take & (req_cfg != cfg_q)));
        stat_keep.ovr = bus_wdata[STAT_OVR_BIT];
        stat_keep.udr = bus_wdata[STAT_UDR_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            irq_en_q <= 1'b0;
        end else if (ctrl_wr) begin
            irq_en_q <= bus_wdata[CTRL_IRQ_BIT];
            if (cfg_take) cfg_q <= req_cfg;
        end
    end

    // ---------------- direction variant ----------------
    generate
        if (IS_TX) begin : g_tx
            assign push_req   = data_wr;
            assign push_data  = bus_wdata[DATA_W-1:0];
            assign pop_req    = port_pop;
            assign port_rdata = ram_q;
            assign irq        = irq_en_q & (frames <= half_frames);
        end else begin : g_rx
            assign push_req   = port_push;
            assign push_data  = port_wdata;
            assign pop_req    = data_rd;
            assign port_rdata = '0;
            assign irq        = irq_en_q & (frames >= half_frames);
        end
    endgenerate

    // ---------------- datapath ----------------
    asf_geometry #(.CNT_W(CNT_W)) u_geom (
        .cfg         (cfg_q),
        .cap_words   (cap_words),
        .half_frames (half_frames)
    );

    asf_tracker #(.AW(AW), .CNT_W(CNT_W)) u_track (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .push_req  (push_req),
        .pop_req   (pop_req),
        .chan_m1   (cfg_q.chan_m1),
        .cap_words (cap_words),
        .stat_wr   (stat_wr),
        .stat_keep (stat_keep),
        .push_ok   (push_ok),
        .pop_ok    (pop_ok),
        .pop_empty (pop_empty),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .words     (words),
        .frames    (frames),
        .flags     (flags)
    );

    asf_ram #(.AW(AW), .DW(DATA_W)) u_ram (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (push_ok),
        .wr_addr (wr_ptr),
        .wr_data (push_data),
        .rd_en   (pop_ok),
        .rd_addr (rd_ptr),
        .rd_zero (pop_empty),
        .rd_data (ram_q)
    );

    // ---------------- read-back ----------------
    always_comb begin
        lvl_view = (frames > CNT_W'(511)) ? LVL_W'(511) : LVL_W'(frames);
        ctrl_view = '0;
        ctrl_view[CTRL_IRQ_BIT]        = irq_en_q;
        ctrl_view[CTRL_SZ_LSB +: 3]    = cfg_q.size_code;
        ctrl_view[CTRL_CH_LSB +: 3]    = cfg_q.chan_m1;
        stat_view = '0;
        stat_view[STAT_LVL_LSB +: LVL_W] = lvl_view;
        stat_view[STAT_OVR_BIT]          = flags.ovr;
        stat_view[STAT_UDR_BIT]          = flags.udr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_reg_q      <= '0;
            rd_from_ram_q <= 1'b0;
        end else if (acc_rd) begin
            rd_from_ram_q <= (reg_sel == ASF_REG_DATA) & ~IS_TX;
            case (reg_sel)
                ASF_REG_CTRL: rd_reg_q <= ctrl_view;
                ASF_REG_STAT: rd_reg_q <= stat_view;
                default:      rd_reg_q <= '0;
            endcase
        end
    end

    assign bus_rdata = rd_from_ram_q ? {{(BUS_W-DATA_W){1'b0}}, ram_q} : rd_reg_q;

    AST_UDR_ZERO: assert property (@(posedge clk) disable iff (rst)
        pop_empty |=> (ram_q == '0));                                   // R5
    AST_CFG_LOCK: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !bus_wdata[CTRL_CLR_BIT] && words != '0) |=> $stable(cfg_q)); // R11

endmodule

// File: tb/test_audio_sample_fifo.sv
module test_audio_sample_fifo;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_tx = 1'b0, sel_rx = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata_tx, rdata_rx;
    logic        tx_pop = 1'b0, rx_push = 1'b0;
    logic [23:0] rx_wdata = '0;
    logic [23:0] tx_rdata, rx_rdata_unused;
    logic        irq_tx, irq_rx;

    always #4 clk = ~clk;   // 125 MHz

    audio_sample_fifo #(.IS_TX(1'b1), .MAX_SIZE_CODE(2)) i_audio_sample_fifo (
        .clk(clk), .rst(rst), .bus_sel(sel_tx), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_tx), .port_push(1'b0), .port_wdata(24'd0),
        .port_pop(tx_pop), .port_rdata(tx_rdata), .irq(irq_tx));

    audio_sample_fifo #(.IS_TX(1'b0), .MAX_SIZE_CODE(2)) i_audio_sample_fifo_rx (
        .clk(clk), .rst(rst), .bus_sel(sel_rx), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_rx), .port_push(rx_push), .port_wdata(rx_wdata),
        .port_pop(1'b0), .port_rdata(rx_rdata_unused), .irq(irq_rx));

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // reference model of the transmit instance
    logic [23:0] m_q[$];
    int m_ch = 1, m_sz = 0, m_frames = 0, m_wslot = 0, m_rslot = 0;
    bit m_ovr = 0, m_udr = 0;

    function automatic int cap_frames_f(input int chm1, input int sz);
        int s, sh;
        s  = (sz > 2) ? 2 : sz;
        sh = (chm1 == 0) ? 0 : (chm1 == 1) ? 1 : (chm1 <= 3) ? 2 : 3;
        return (256 << s) >> sh;
    endfunction

    function automatic logic [31:0] exp_stat();
        int l;
        l = (m_frames > 511) ? 511 : m_frames;
        return (32'(l) << 8) | (32'(m_ovr) << 4) | 32'(m_udr);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic m_clear();
        m_q.delete();
        m_frames = 0; m_wslot = 0; m_rslot = 0;
    endtask

    task automatic cpu_wr(input bit rx, input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        sel_tx = !rx; sel_rx = rx; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        sel_tx = 1'b0; sel_rx = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic cpu_rd(input bit rx, input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        sel_tx = !rx; sel_rx = rx; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        sel_tx = 1'b0; sel_rx = 1'b0;
        d = rx ? rdata_rx : rdata_tx;
    endtask

    task automatic set_cfg(input int chm1, input int sz, input bit ien);
        cpu_wr(1'b0, 2'd0, (32'(ien) << 20) | (32'(sz) << 8) | (32'(chm1) << 4) | 32'd1);
        m_ch = chm1 + 1; m_sz = (sz > 2) ? 2 : sz;
        m_clear();
    endtask

    task automatic tx_write(input logic [31:0] d);
        cpu_wr(1'b0, 2'd2, d);
        if (m_q.size() < cap_frames_f(m_ch - 1, m_sz) * m_ch) begin
            m_q.push_back(d[23:0]);
            m_wslot++;
            if (m_wslot == m_ch) begin m_wslot = 0; m_frames++; end
        end else m_ovr = 1;
    endtask

    task automatic tx_pop_chk(input string req);
        logic [23:0] got, exp;
        @(negedge clk); tx_pop = 1'b1;
        @(negedge clk); tx_pop = 1'b0;
        got = tx_rdata;
        if (m_frames == 0) begin exp = '0; m_udr = 1; end
        else begin
            exp = m_q.pop_front();
            m_rslot++;
            if (m_rslot == m_ch) begin m_rslot = 0; m_frames--; end
        end
        chk(req, 32'(got), 32'(exp));
    endtask

    task automatic stat_chk(input string req);
        logic [31:0] v;
        cpu_rd(1'b0, 2'd1, v);
        chk(req, v, exp_stat());
    endtask

    task automatic clear_flags();
        cpu_wr(1'b0, 2'd1, 32'd0);
        m_ovr = 0; m_udr = 0;
    endtask

    task automatic fill_test(input int chm1, input int sz, input string req);
        int capw;
        set_cfg(chm1, sz, 1'b0);
        capw = cap_frames_f(chm1, sz) * (chm1 + 1);
        for (int i = 0; i < capw; i++) tx_write($urandom());
        stat_chk(req);
        tx_write($urandom());
        stat_chk("R4 overrun at capacity");
        clear_flags();
    endtask

    task automatic rx_push_w(input logic [23:0] d);
        @(negedge clk); rx_push = 1'b1; rx_wdata = d;
        @(negedge clk); rx_push = 1'b0;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R12 watchdog: actual running expected finished");
            report();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [23:0] rx_ref[$];
        void'($urandom(32'd91357));
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // reset state
        stat_chk("R12 reset status");
        cpu_rd(1'b0, 2'd0, v); chk("R12 reset control", v, 32'd0);
        chk("R8 reset irq", 32'(irq_tx), 32'd0);

        // three channels, partial frames, capacity, order, underrun
        set_cfg(2, 0, 1'b0);
        tx_write($urandom()); tx_write($urandom());
        stat_chk("R3 partial frame not counted");
        tx_write($urandom());
        stat_chk("R3 one complete frame");
        for (int i = 3; i < 192; i++) tx_write($urandom());
        stat_chk("R1 three channels hold 64 frames");
        tx_write(32'hFFFF_FFFF);
        stat_chk("R4 overrun flag");
        for (int i = 0; i < 192; i++) tx_pop_chk("R10 R9 sample order and width");
        tx_pop_chk("R5 underrun returns zero");
        stat_chk("R5 underrun flag");
        cpu_wr(1'b0, 2'd1, 32'h10); m_udr = 0;
        stat_chk("R6 clear underrun only");
        clear_flags();
        stat_chk("R6 clear both");

        fill_test(4, 0, "R1 five channels hold 32 frames");
        fill_test(7, 0, "R1 eight channels hold 32 frames");
        fill_test(0, 1, "R2 level saturates at 511");
        fill_test(1, 7, "R1 clamped size code");
        cpu_rd(1'b0, 2'd0, v); chk("R1 clamped code readback", v, (32'd2 << 8) | (32'd1 << 4));

        // configuration lock
        set_cfg(0, 0, 1'b0);
        tx_write(32'h0000_1234);
        cpu_wr(1'b0, 2'd0, 32'd3 << 4);
        cpu_rd(1'b0, 2'd0, v); chk("R11 config kept while data held", v, 32'd0);
        stat_chk("R11 data kept while locked");
        cpu_wr(1'b0, 2'd0, (32'd3 << 4) | 32'd1); m_ch = 4; m_clear();
        cpu_rd(1'b0, 2'd0, v); chk("R11 config taken with clear", v, 32'd3 << 4);
        stat_chk("R11 change empties");

        // clear command keeps flags
        set_cfg(0, 0, 1'b0);
        for (int i = 0; i < 257; i++) tx_write($urandom());
        cpu_wr(1'b0, 2'd0, 32'd1); m_clear();
        stat_chk("R7 clear empties, flags kept");
        cpu_rd(1'b0, 2'd0, v); chk("R7 clear bit reads zero", v, 32'd0);
        clear_flags();

        // transmit half-level interrupt
        set_cfg(0, 0, 1'b1);
        chk("R8 tx irq when empty", 32'(irq_tx), 32'd1);
        for (int i = 0; i < 128; i++) tx_write($urandom());
        chk("R8 tx irq at half", 32'(irq_tx), 32'd1);
        tx_write($urandom());
        chk("R8 tx irq above half", 32'(irq_tx), 32'd0);
        for (int i = 0; i < 2; i++) tx_pop_chk("R10 drain");
        chk("R8 tx irq back at half", 32'(irq_tx), 32'd1);
        cpu_wr(1'b0, 2'd0, 32'd0);
        chk("R8 irq disabled", 32'(irq_tx), 32'd0);

        // receive instance
        cpu_wr(1'b1, 2'd0, (32'd1 << 20) | 32'd1);
        for (int i = 0; i < 127; i++) begin
            logic [23:0] d;
            d = 24'($urandom());
            rx_ref.push_back(d);
            rx_push_w(d);
        end
        chk("R8 rx irq below half", 32'(irq_rx), 32'd0);
        rx_push_w(24'hABCDEF); rx_ref.push_back(24'hABCDEF);
        chk("R8 rx irq at half", 32'(irq_rx), 32'd1);
        for (int i = 0; i < 128; i++) begin
            cpu_rd(1'b1, 2'd2, v);
            chk("R9 R10 R12 rx data read", v, {8'h00, rx_ref.pop_front()});
        end
        cpu_rd(1'b1, 2'd2, v); chk("R5 rx underrun returns zero", v, 32'd0);
        cpu_rd(1'b1, 2'd1, v); chk("R5 rx underrun flag", v, 32'd1);

        // constrained random on the transmit instance
        set_cfg($urandom_range(0, 3), 0, 1'b1);
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r <= 4)      tx_write($urandom());
            else if (r <= 7) tx_pop_chk("R10 random pop");
            else if (r == 8) stat_chk("R2 random status");
            else chk("R8 random irq", 32'(irq_tx),
                     32'(m_frames <= cap_frames_f(m_ch - 1, m_sz) / 2));
        end

        done = 1'b1;
        report();
        $finish;
    end

endmodule